// File: doc/BRIEF.md
# Microprogrammed 8-bit Processor Sequencer

This block is a small 8-bit processor whose control comes entirely from a microcode lookup. A 4-bit step counter, the current opcode and one condition bit select a microword. The microword names exactly one source for the internal data bus, which is the program ROM, the ALU or the data RAM. It also names one destination: the opcode register, the program address, register A, register B, the memory address register or a RAM write. It further gives an ALU function, a condition-code action and whether the program address steps forward. The program ROM lives outside the block and is read combinationally at `prog_addr`. The 256-byte data RAM is inside the block and is written so that block RAM can be inferred.

Five instructions are defined. These are memory-to-memory add, add-immediate, unconditional jump, branch-on-shifted-flag and push-to-stack. Every instruction ends with a step that fetches the next opcode. Any other opcode runs only that fetch step and so acts as a one-cycle no-op. RAM writes are visible at the ports, together with the architectural registers, so that software results can be traced.

Top module: `mcpu_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `prog_addr`, `opcode`, `phase`, `reg_a`, `reg_b` and `cc` are all zero.
- R2: A fetch step does three things at one edge: it loads `opcode` with the ROM byte at `prog_addr`, it increments `prog_addr`, and it clears `phase` to 0.
- R3: On every edge without an opcode load, `phase` increases by exactly one.
- R4: Opcode 0x0A, followed by ROM bytes x, y, z, writes RAM[x]+RAM[y] to RAM[z] on its sixth edge after the fetch. It fetches the next opcode on its seventh edge.
- R5: Opcode 0x0B, followed by ROM bytes k, y, z, loads A with k and writes k+RAM[y] to RAM[z] on its fifth edge. It fetches on its sixth edge.
- R6: Opcode 0x0C, followed by ROM bytes t and one filler byte, sets `prog_addr` to t. The opcode at t is fetched on the fourth edge.
- R7: Opcode 0x17, followed by bytes t and one filler byte, branches to t when the shifted-out flag is 1. The opcode at t is fetched on the fifth edge.
- R8: When the shifted-out flag of 0x17 is 0, both operand bytes are skipped. The next opcode is fetched on the fourth edge.
- R9: A RAM write of an ALU result latches `cc` with bit 0 = result is zero and bit 1 = result bit 7. Other steps hold `cc`, except the shift step of 0x17, which moves bit 0 out as the branch flag and moves bit 1 down into bit 0.
- R10: Opcode 0x03, followed by address v, reads the stack pointer s at RAM[0xFF] and writes s-1 to RAM[0xFF] on its third edge. It writes RAM[v] to RAM[s] on its seventh edge and fetches on its eighth edge.
- R11: Any other opcode, 0x00 included, is a one-cycle no-op. The next opcode is fetched on the edge right after its own fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_addr | output | 8 | Program ROM address (program counter) |
| prog_data | input | 8 | Program ROM byte at `prog_addr`, combinational |
| ram_we | output | 1 | Data RAM write in the current step |
| ram_waddr | output | 8 | Data RAM write address |
| ram_wdata | output | 8 | Data RAM write value |
| opcode | output | 8 | Current opcode register |
| phase | output | 4 | Micro-step counter |
| reg_a | output | 8 | Register A |
| reg_b | output | 8 | Register B |
| cc | output | 2 | Condition codes: bit 0 zero, bit 1 negative |

## Verification
Every result depends on a fixed step count from the fetch. A write is visible on `ram_we` during the step that performs it, and registers change one edge after the step that loads them. The bench counts edges from reset release and records each write with the number of the edge that commits it. It then compares that edge number with the expected value for each instruction: the sixth edge for 0x0A, the fifth for 0x0B, and the third and seventh for 0x03. Register and flag checks are made at the falling edge after the exact edge of the fetch or latch they test. Taken and skipped branches are told apart by the fetch address at the predicted edge, and by trap instructions whose writes must never show up.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  localparam int WORD_W  = 8;
  localparam int PHASE_W = 4;

  // bus source, one-hot
  localparam logic [2:0] SRC_ROM = 3'b001;
  localparam logic [2:0] SRC_ALU = 3'b010;
  localparam logic [2:0] SRC_RAM = 3'b100;

  // destination, encoded
  localparam logic [2:0] DST_OP  = 3'd0;
  localparam logic [2:0] DST_ADR = 3'd1;
  localparam logic [2:0] DST_A   = 3'd2;
  localparam logic [2:0] DST_B   = 3'd3;
  localparam logic [2:0] DST_RAM = 3'd4;
  localparam logic [2:0] DST_MAR = 3'd5;

  localparam logic [1:0] CC_HOLD  = 2'b11;
  localparam logic [1:0] CC_LATCH = 2'b00;
  localparam logic [1:0] CC_SHIFT = 2'b01;

  localparam logic [5:0] FN_PASSA = 6'b111111;
  localparam logic [5:0] FN_ADD   = 6'b100110;
  localparam logic [5:0] FN_DEC   = 6'b111110;
  localparam logic [5:0] FN_PASSB = 6'b101011;
  localparam logic [5:0] FN_ONES  = 6'b110011;

  localparam logic [7:0] OPC_ADDM = 8'h0A;
  localparam logic [7:0] OPC_ADDI = 8'h0B;
  localparam logic [7:0] OPC_JMP  = 8'h0C;
  localparam logic [7:0] OPC_BRF  = 8'h17;
  localparam logic [7:0] OPC_PUSH = 8'h03;

  typedef struct packed {
    logic       step;   // program address increment
    logic [5:0] fn;
    logic [1:0] ccact;
    logic [2:0] src;
    logic [2:0] dst;
  } uword_t;

  function automatic uword_t mk(input logic step, input logic [5:0] fn,
                                input logic [1:0] ccact, input logic [2:0] src,
                                input logic [2:0] dst);
    uword_t w;
    w.step  = step;
    w.fn    = fn;
    w.ccact = ccact;
    w.src   = src;
    w.dst   = dst;
    return w;
  endfunction

endpackage

// File: rtl/mcpu_ustore.sv
module mcpu_ustore
  import mcpu_pkg::*;
#(
  parameter int OW  = WORD_W,
  parameter int PHW = PHASE_W
) (
  input  logic [OW-1:0]  op,
  input  logic [PHW-1:0] ph,
  input  logic           flag,
  output uword_t         uw
);

  uword_t w_fetch, w_mar_rom, w_a_rom;

  always_comb begin
    w_fetch   = mk(1'b1, FN_PASSA, CC_HOLD, SRC_ROM, DST_OP);
    w_mar_rom = mk(1'b1, FN_PASSA, CC_HOLD, SRC_ROM, DST_MAR);
    w_a_rom   = mk(1'b1, FN_PASSA, CC_HOLD, SRC_ROM, DST_A);
    uw        = w_fetch;
    case (op)
      OPC_ADDM: case (ph)
        4'd0, 4'd2, 4'd4: uw = w_mar_rom;
        4'd1: uw = mk(1'b0, FN_PASSA, CC_HOLD, SRC_RAM, DST_A);
        4'd3: uw = mk(1'b0, FN_PASSA, CC_HOLD, SRC_RAM, DST_B);
        4'd5: uw = mk(1'b0, FN_ADD, CC_LATCH, SRC_ALU, DST_RAM);
        default: uw = w_fetch;
      endcase
      OPC_ADDI: case (ph)
        4'd0: uw = w_a_rom;
        4'd1, 4'd3: uw = w_mar_rom;
        4'd2: uw = mk(1'b0, FN_PASSA, CC_HOLD, SRC_RAM, DST_B);
        4'd4: uw = mk(1'b0, FN_ADD, CC_LATCH, SRC_ALU, DST_RAM);
        default: uw = w_fetch;
      endcase
      OPC_JMP: case (ph)
        4'd0: uw = w_a_rom;
        4'd1: uw = mk(1'b0, FN_PASSA, CC_HOLD, SRC_ROM, DST_ADR);
        4'd2: uw = mk(1'b0, FN_PASSA, CC_HOLD, SRC_ALU, DST_ADR);
        default: uw = w_fetch;
      endcase
      OPC_BRF: case (ph)
        4'd0: uw = w_a_rom;
        4'd1: uw = mk(1'b0, FN_PASSA, CC_SHIFT, SRC_ALU, DST_A);
        4'd2: uw = flag ? mk(1'b0, FN_PASSA, CC_HOLD, SRC_ROM, DST_ADR) : w_a_rom;
        4'd3: uw = flag ? mk(1'b0, FN_PASSA, CC_HOLD, SRC_ALU, DST_ADR) : w_fetch;
        default: uw = w_fetch;
      endcase
      OPC_PUSH: case (ph)
        4'd0: uw = mk(1'b0, FN_ONES, CC_HOLD, SRC_ALU, DST_MAR);
        4'd1: uw = mk(1'b0, FN_PASSA, CC_HOLD, SRC_RAM, DST_A);
        4'd2: uw = mk(1'b0, FN_DEC, CC_HOLD, SRC_ALU, DST_RAM);
        4'd3: uw = w_mar_rom;
        4'd4: uw = mk(1'b0, FN_PASSA, CC_HOLD, SRC_RAM, DST_B);
        4'd5: uw = mk(1'b0, FN_PASSA, CC_HOLD, SRC_ALU, DST_MAR);
        4'd6: uw = mk(1'b0, FN_PASSB, CC_HOLD, SRC_ALU, DST_RAM);
        default: uw = w_fetch;
      endcase
      default: uw = w_fetch;
    endcase
  end

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [5:0]    fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero,
  output logic          neg
);

  always_comb begin
    case (fn)
      FN_ADD:   y = a + b;
      FN_DEC:   y = a - 1'b1;
      FN_PASSB: y = b;
      FN_ONES:  y = '1;
      default:  y = a;
    endcase
    zero = (y == '0);
    neg  = y[DW-1];
  end

endmodule

// File: rtl/mcpu_dmem.sv
module mcpu_dmem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int DW  = WORD_W,
  parameter int PHW = PHASE_W
) (
  input  logic           clk,
  input  logic           rst,
  output logic [DW-1:0]  prog_addr,
  input  logic [DW-1:0]  prog_data,
  output logic           ram_we,
  output logic [DW-1:0]  ram_waddr,
  output logic [DW-1:0]  ram_wdata,
  output logic [DW-1:0]  opcode,
  output logic [PHW-1:0] phase,
  output logic [DW-1:0]  reg_a,
  output logic [DW-1:0]  reg_b,
  output logic [1:0]     cc
);

  localparam int AW = DW;

  uword_t         uw;
  logic [AW-1:0]  adr_q, mar_q, mar_d;
  logic [DW-1:0]  a_q, b_q, op_q, bus, alu_y, ram_q;
  logic [PHW-1:0] ph_q;
  logic [1:0]     cc_q;
  logic           flag_q, alu_z, alu_n, ld_op;

  mcpu_ustore #(.OW(DW), .PHW(PHW)) u_store (
    .op(op_q), .ph(ph_q), .flag(flag_q), .uw(uw)
  );

  mcpu_alu #(.DW(DW)) u_alu (
    .fn(uw.fn), .a(a_q), .b(b_q), .y(alu_y), .zero(alu_z), .neg(alu_n)
  );

  assign ld_op = (uw.dst == DST_OP);
  assign mar_d = (uw.dst == DST_MAR) ? bus : mar_q;

  mcpu_dmem #(.DW(DW), .AW(AW)) u_dmem (
    .clk(clk), .we(ram_we), .waddr(mar_q), .wdata(bus),
    .raddr(mar_d), .rdata(ram_q)
  );

  // one-hot AND-OR bus
  always_comb begin
    bus = ({DW{uw.src[0]}} & prog_data)
        | ({DW{uw.src[1]}} & alu_y)
        | ({DW{uw.src[2]}} & ram_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_q  <= '0;
      mar_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      op_q   <= '0;
      ph_q   <= '0;
      cc_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      ph_q <= ld_op ? '0 : ph_q + 1'b1;
      if (uw.dst == DST_ADR)  adr_q <= bus;
      else if (uw.step)       adr_q <= adr_q + 1'b1;
      if (ld_op)              op_q  <= bus;
      if (uw.dst == DST_A)    a_q   <= bus;
      if (uw.dst == DST_B)    b_q   <= bus;
      if (uw.dst == DST_MAR)  mar_q <= bus;
      case (uw.ccact)
        CC_LATCH: cc_q <= {alu_n, alu_z};
        CC_SHIFT: begin
          flag_q <= cc_q[0];
          cc_q   <= {1'b0, cc_q[1]};
        end
        default: ;
      endcase
    end
  end

  assign prog_addr = adr_q;
  assign ram_we    = (uw.dst == DST_RAM);
  assign ram_waddr = mar_q;
  assign ram_wdata = bus;
  assign opcode    = op_q;
  assign phase     = ph_q;
  assign reg_a     = a_q;
  assign reg_b     = b_q;
  assign cc        = cc_q;

  // R2: a fetch restarts the step counter
  p_phase_clear_r2: assert property (@(posedge clk) disable iff (rst)
    ld_op |=> (ph_q == '0));

  // R2: program address steps forward when requested and not loaded
  p_adr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (uw.step && uw.dst != DST_ADR) |=> (adr_q == $past(adr_q) + 1'b1));

  // R3: step counter advances by one otherwise
  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    !ld_op |=> (ph_q == $past(ph_q) + 1'b1));

  // R9: shift moves bit 0 into the branch flag
  p_cc_shift_r9: assert property (@(posedge clk) disable iff (rst)
    (uw.ccact == CC_SHIFT) |=> (flag_q == $past(cc_q[0]) && cc_q[1] == 1'b0));

  // R9: hold keeps the flags
  p_cc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (uw.ccact == CC_HOLD) |=> $stable(cc_q));

endmodule

// File: tb/mcpu_core_tb_top.sv
module mcpu_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] prog_addr, prog_data, ram_waddr, ram_wdata, opcode, reg_a, reg_b;
  logic [3:0] phase;
  logic [1:0] cc;
  logic       ram_we;
  logic [7:0] rom [256];

  always #10 clk = ~clk;

  assign prog_data = rom[prog_addr];

  mcpu_core dut_i (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_data(prog_data),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .opcode(opcode), .phase(phase), .reg_a(reg_a), .reg_b(reg_b), .cc(cc)
  );

  int edges = 0;
  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  // write log: edge that commits each write
  int         nw = 0;
  int         wcyc [16];
  logic [7:0] wadr [16];
  logic [7:0] wdat [16];
  always @(negedge clk) begin
    if (!rst && ram_we) begin
      if (nw < 16) begin
        wcyc[nw] = edges + 1;
        wadr[nw] = ram_waddr;
        wdat[nw] = ram_wdata;
      end
      nw++;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic at_edge(int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic chk_wr(string req, int idx, int cyc, int adr, int dat);
    chk(req, "write present", int'(nw > idx), 1);
    if (nw > idx) begin
      chk(req, "write edge", wcyc[idx], cyc);
      chk(req, "write addr", int'(wadr[idx]), adr);
      chk(req, "write data", int'(wdat[idx]), dat);
    end
  endtask

  task automatic put(int adr, logic [7:0] v);
    rom[adr] = v;
  endtask

  task automatic load_rom();
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    put(0, 8'h0B); put(1, 8'h05); put(2, 8'h10); put(3, 8'h20);
    put(4, 8'h0B); put(5, 8'h80); put(6, 8'h10); put(7, 8'hFF);
    put(8, 8'h0B); put(9, 8'hFB); put(10, 8'h20); put(11, 8'h21);
    put(12, 8'h17); put(13, 8'h18); put(14, 8'h99);
    put(15, 8'h0B); put(16, 8'hEE); put(17, 8'h10); put(18, 8'h30);
    put(24, 8'h0A); put(25, 8'h20); put(26, 8'h20); put(27, 8'h22);
    put(28, 8'h17); put(29, 8'h40); put(30, 8'h77);
    put(31, 8'h0B); put(32, 8'hF0); put(33, 8'h20); put(34, 8'h23);
    put(35, 8'h17); put(36, 8'h50); put(37, 8'h00);
    put(38, 8'h17); put(39, 8'h2D); put(40, 8'h00);
    put(41, 8'h0B); put(42, 8'hEE); put(43, 8'h10); put(44, 8'h31);
    put(45, 8'h0C); put(46, 8'h34); put(47, 8'h00);
    put(48, 8'h0B); put(49, 8'hEE); put(50, 8'h10); put(51, 8'h32);
    put(52, 8'h03); put(53, 8'h20);
    put(54, 8'hC5);
    put(55, 8'h0A); put(56, 8'h80); put(57, 8'hFF); put(58, 8'h24);
    put(59, 8'h0C); put(60, 8'h3B); put(61, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1", "prog_addr", prog_addr, 0);
    chk("R1", "opcode", opcode, 0);
    chk("R1", "phase", phase, 0);
    chk("R1", "reg_a", reg_a, 0);
    chk("R1", "reg_b", reg_b, 0);
    chk("R1", "cc", cc, 0);
  endtask

  task automatic t_fetch_step();
    at_edge(1);
    chk("R2", "opcode after fetch", opcode, 8'h0B);
    chk("R2", "prog_addr after fetch", prog_addr, 1);
    chk("R2", "phase after fetch", phase, 0);
    at_edge(2);
    chk("R3", "phase advance", phase, 1);
    chk("R5", "A from immediate", reg_a, 8'h05);
  endtask

  task automatic t_add_imm();
    at_edge(18);
    chk_wr("R5", 0, 6, 8'h20, 8'h05);
    chk_wr("R5", 1, 12, 8'hFF, 8'h80);
    chk_wr("R5", 2, 18, 8'h21, 8'h00);
    chk("R9", "cc zero latched", cc, 2'b01);
  endtask

  task automatic t_branch_taken_zero();
    at_edge(24);
    chk("R7", "opcode at target", opcode, 8'h0A);
    chk("R7", "prog_addr past target", prog_addr, 25);
  endtask

  task automatic t_add_mem();
    at_edge(30);
    chk_wr("R4", 3, 30, 8'h22, 8'h0A);
    chk("R9", "cc cleared by nonzero sum", cc, 2'b00);
    at_edge(31);
    chk("R4", "fetch after add", opcode, 8'h17);
  endtask

  task automatic t_branch_skip();
    at_edge(35);
    chk("R8", "opcode after skip", opcode, 8'h0B);
    chk("R8", "prog_addr after skip", prog_addr, 32);
    at_edge(40);
    chk_wr("R5", 4, 40, 8'h23, 8'hF5);
    chk("R9", "cc negative latched", cc, 2'b10);
    at_edge(43);
    chk("R9", "cc after shift", cc, 2'b01);
    at_edge(45);
    chk("R8", "second skip fetch", prog_addr, 39);
  endtask

  task automatic t_branch_taken_neg();
    at_edge(47);
    chk("R9", "cc after second shift", cc, 2'b00);
    at_edge(50);
    chk("R7", "opcode at target", opcode, 8'h0C);
    chk("R7", "prog_addr past target", prog_addr, 46);
  endtask

  task automatic t_jump();
    at_edge(54);
    chk("R6", "opcode at jump target", opcode, 8'h03);
    chk("R6", "prog_addr past target", prog_addr, 53);
  endtask

  task automatic t_push();
    at_edge(62);
    chk_wr("R10", 5, 57, 8'hFF, 8'h7F);
    chk_wr("R10", 6, 61, 8'h80, 8'h05);
    chk("R10", "fetch after push", opcode, 8'hC5);
    chk("R10", "prog_addr after push", prog_addr, 55);
  endtask

  task automatic t_nop();
    at_edge(63);
    chk("R11", "opcode after no-op", opcode, 8'h0A);
    chk("R11", "phase after no-op", phase, 0);
    chk("R11", "prog_addr after no-op", prog_addr, 56);
  endtask

  task automatic t_final();
    at_edge(69);
    chk_wr("R4", 7, 69, 8'h24, 8'h84);
    chk("R4", "A from RAM", reg_a, 8'h05);
    chk("R4", "B from RAM", reg_b, 8'h7F);
    chk("R9", "cc negative", cc, 2'b10);
    at_edge(100);
    chk("R6", "no trap writes", nw, 8);
  endtask

  initial begin
    load_rom();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fetch_step();
    t_add_imm();
    t_branch_taken_zero();
    t_add_mem();
    t_branch_skip();
    t_branch_taken_neg();
    t_jump();
    t_push();
    t_nop();
    t_final();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule